// File: doc/BRIEF.md
# Shadow RAM Attribute Router

This block decides, for each memory cycle that lands in the legacy firmware area below 1 MB, whether the cycle is served by local DRAM or passed to the expansion bus where the ROM devices sit. The window from C0000h up to FFFFFh is divided into sixteen 16 KB segments. Each segment holds a 2-bit attribute that steers reads and writes on their own. Because reads and writes to one address can go to different targets, firmware can copy a ROM image into the RAM underneath it in place: it reads from the ROM and writes to DRAM. It then makes the segment read-only in DRAM, and from that point writes go out to the bus.

A configuration write port updates one segment attribute per cycle. Requests arrive with an address, a write flag and a valid/ready handshake. The routing decision comes back one cycle later from a registered output stage with its own valid/ready pair. Addresses outside the window skip the attribute table and take the route given on a default-route input.

Top module: `shadow_router`

## Requirements
- R1: After reset every segment attribute is 00, so every cycle inside the window goes to the expansion bus. `rsp_valid` is low and `req_ready` is high.
- R2: An address inside [C0000h, 100000h) belongs to segment (addr - C0000h) >> 14, numbered 0 to 15. `cfg_seg` uses the same numbering.
- R3: A read inside the window goes to DRAM (`rsp_to_dram` = 1) when bit 0 of its segment attribute is 1. Otherwise it goes to the expansion bus (`rsp_to_dram` = 0).
- R4: A write inside the window goes to DRAM when bit 1 of its segment attribute is 1. Otherwise it goes to the expansion bus.
- R5: With attribute 10 (copy phase), reads of the segment go to the bus and writes to the same addresses go to DRAM.
- R6: With attribute 01 (read-only shadow), reads are served from DRAM and every write is forwarded to the expansion bus.
- R7: A request outside the window returns the value of `dflt_to_dram` that was sampled when the request was accepted.
- R8: A configuration write takes effect on the following cycle. A request accepted in the same cycle as the configuration write is routed with the old attribute.
- R9: A request accepted on a clock edge (`req_valid` and `req_ready` both high) gives `rsp_valid` = 1 with its decision right after that edge.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response stays valid and unchanged and `req_ready` is low.
- R11: A configuration write changes only the addressed segment. All other segment attributes keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Attribute write strobe |
| cfg_seg | input | 4 | Segment number to update |
| cfg_attr | input | 2 | New attribute: bit 1 routes writes to DRAM, bit 0 routes reads to DRAM |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| dflt_to_dram | input | 1 | Route for addresses outside the window (1 = DRAM) |
| rsp_valid | output | 1 | Routing decision available |
| rsp_ready | input | 1 | Consumer takes the decision |
| rsp_to_dram | output | 1 | 1 = DRAM, 0 = expansion bus |

## Verification
A configuration write and a routed request can fall on the same clock edge and target the same segment. The bench drives both in one cycle to segment 3, raising its attribute from 00 to 11, with a read that hits that segment. The first response must still go to the bus. A second read issued right after must go to DRAM. A stalled response can also overlap a new request. That case is provoked by holding `rsp_ready` low: the held decision must stay the same, and the waiting request is taken on the edge where the stall ends.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

    // Per-segment routing attribute; bit 1 steers writes, bit 0 steers reads
    typedef struct packed {
        logic wr_dram;
        logic rd_dram;
    } seg_attr_t;

    localparam seg_attr_t ATTR_ALL_BUS = '{wr_dram: 1'b0, rd_dram: 1'b0};

    // Registered response stage
    typedef struct packed {
        logic vld;
        logic to_dram;
    } rsp_stage_t;

    function automatic logic pick_target(input seg_attr_t a, input logic is_write);
        return is_write ? a.wr_dram : a.rd_dram;
    endfunction

endpackage

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode #(
    parameter int unsigned          ADDR_W    = 32,
    parameter logic [ADDR_W-1:0]    WIN_BASE  = 'hC0000,
    parameter logic [ADDR_W-1:0]    WIN_LIMIT = 'h100000,
    parameter int unsigned          SEG_SHIFT = 14,
    parameter int unsigned          SEG_W     = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output logic [SEG_W-1:0]  seg
);
    logic [ADDR_W-1:0] offset;

    always_comb begin
        // R2: window bounds and segment index
        in_win = (addr >= WIN_BASE) && (addr < WIN_LIMIT);
        offset = addr - WIN_BASE;
        seg    = offset[SEG_SHIFT +: SEG_W];
    end
endmodule

// File: rtl/shadow_attr_table.sv
module shadow_attr_table
    import shadow_pkg::*;
#(
    parameter int unsigned NUM_SEG = 16,
    parameter int unsigned SEG_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEG_W-1:0]  wr_seg,
    input  seg_attr_t         wr_attr,
    input  logic [SEG_W-1:0]  rd_seg,
    output seg_attr_t         rd_attr
);
    seg_attr_t attr_q [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        seg_attr_t attr_d;

        // R8, R11: only the addressed segment loads, visible next cycle
        always_comb begin
            attr_d = attr_q[g];
            if (wr_en && (wr_seg == SEG_W'(g))) begin
                attr_d = wr_attr;
            end
        end

        // R1: reset to all-bus
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                attr_q[g] <= ATTR_ALL_BUS;
            end else begin
                attr_q[g] <= attr_d;
            end
        end
    end

    always_comb begin
        rd_attr = ATTR_ALL_BUS;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (rd_seg == SEG_W'(i)) begin
                rd_attr = attr_q[i];
            end
        end
    end
endmodule

// File: rtl/shadow_rsp_stage.sv
module shadow_rsp_stage
    import shadow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    input  logic in_to_dram,
    output logic out_valid,
    input  logic out_ready,
    output logic out_to_dram
);
    rsp_stage_t st_d, st_q;

    always_comb begin
        // R10: accept only when the stage is empty or draining
        in_ready = !st_q.vld || out_ready;
        st_d     = st_q;
        if (in_ready) begin
            st_d.vld = in_valid;
            if (in_valid) begin
                st_d.to_dram = in_to_dram;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{vld: 1'b0, to_dram: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.vld;
    assign out_to_dram = st_q.to_dram;
endmodule

// File: rtl/shadow_router.sv
module shadow_router
    import shadow_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 'hC0000,
    parameter logic [ADDR_W-1:0] WIN_LIMIT = 'h100000,
    parameter int unsigned       SEG_BYTES = 16384,
    localparam int unsigned      SEG_SHIFT = $clog2(SEG_BYTES),
    localparam int unsigned      NUM_SEG   = (WIN_LIMIT - WIN_BASE) / SEG_BYTES,
    localparam int unsigned      SEG_W     = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEG_W-1:0]  cfg_seg,
    input  logic [1:0]        cfg_attr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              dflt_to_dram,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_to_dram
);
    logic             hit_win;
    logic [SEG_W-1:0] hit_seg;
    seg_attr_t        hit_attr;
    logic             route_dram;

    shadow_seg_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_LIMIT(WIN_LIMIT),
        .SEG_SHIFT(SEG_SHIFT),
        .SEG_W    (SEG_W)
    ) u_dec (
        .addr  (req_addr),
        .in_win(hit_win),
        .seg   (hit_seg)
    );

    shadow_attr_table #(
        .NUM_SEG(NUM_SEG),
        .SEG_W  (SEG_W)
    ) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_seg (cfg_seg),
        .wr_attr(seg_attr_t'(cfg_attr)),
        .rd_seg (hit_seg),
        .rd_attr(hit_attr)
    );

    // R3, R4, R5, R6, R7: pick the target from the current (old) attribute
    always_comb begin
        route_dram = hit_win ? pick_target(hit_attr, req_write) : dflt_to_dram;
    end

    // R9, R10
    shadow_rsp_stage u_rsp (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (req_valid),
        .in_ready   (req_ready),
        .in_to_dram (route_dram),
        .out_valid  (rsp_valid),
        .out_ready  (rsp_ready),
        .out_to_dram(rsp_to_dram)
    );
endmodule

// File: rtl/shadow_router_chk.sv
module shadow_router_chk #(
    parameter int unsigned       ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 'hC0000,
    parameter logic [ADDR_W-1:0] WIN_LIMIT = 'h100000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              dflt_to_dram,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic              rsp_to_dram
);
    logic outside;
    assign outside = (req_addr < WIN_BASE) || (req_addr >= WIN_LIMIT);

    // R9
    accept_gives_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_valid);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_to_dram));

    // R10
    stall_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |-> !req_ready);

    // R7
    outside_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && outside |=> rsp_to_dram == $past(dflt_to_dram));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid);
endmodule

bind shadow_router shadow_router_chk #(
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE),
    .WIN_LIMIT(WIN_LIMIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .dflt_to_dram(dflt_to_dram),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_to_dram (rsp_to_dram)
);

// File: tb/shadow_router_tb.sv
module shadow_router_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_seg = '0;
    logic [1:0]  cfg_attr = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        dflt_to_dram = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic        rsp_to_dram;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    shadow_router u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_seg(cfg_seg),
        .cfg_attr(cfg_attr), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .dflt_to_dram(dflt_to_dram),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_to_dram(rsp_to_dram)
    );

    typedef struct packed {
        logic        do_cfg;
        logic [3:0]  seg;
        logic [1:0]  attr;
        logic [31:0] addr;
        logic        wr;
        logic        dflt;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd0,  2'b00, 32'h000C0000, 1'b0, 1'b1, 1'b0, 4'd1},  // R1 read, reset attr
        '{1'b0, 4'd0,  2'b00, 32'h000FFFFF, 1'b1, 1'b1, 1'b0, 4'd1},  // R1 write, reset attr
        '{1'b1, 4'd0,  2'b01, 32'h000C0000, 1'b0, 1'b0, 1'b1, 4'd6},  // R6 read-only: read DRAM
        '{1'b0, 4'd0,  2'b00, 32'h000C0000, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 write to bus
        '{1'b1, 4'd5,  2'b10, 32'h000D4000, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 copy: read bus
        '{1'b0, 4'd0,  2'b00, 32'h000D7FFF, 1'b1, 1'b0, 1'b1, 4'd5},  // R5 copy: write DRAM
        '{1'b0, 4'd0,  2'b00, 32'h000C3FFF, 1'b0, 1'b0, 1'b1, 4'd2},  // R2 last byte of seg 0
        '{1'b0, 4'd0,  2'b00, 32'h000C4000, 1'b0, 1'b1, 1'b0, 4'd2},  // R2 first byte of seg 1
        '{1'b1, 4'd15, 2'b11, 32'h000FFFFF, 1'b0, 1'b0, 1'b1, 4'd3},  // R3 read DRAM
        '{1'b0, 4'd0,  2'b00, 32'h000FC000, 1'b1, 1'b0, 1'b1, 4'd4},  // R4 write DRAM
        '{1'b0, 4'd0,  2'b00, 32'h000BFFFF, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 below window
        '{1'b0, 4'd0,  2'b00, 32'h00100000, 1'b1, 1'b0, 1'b0, 4'd7},  // R7 above window
        '{1'b0, 4'd0,  2'b00, 32'h00000000, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 low memory
        '{1'b1, 4'd15, 2'b00, 32'h000FFFFF, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 read back to bus
        '{1'b0, 4'd0,  2'b00, 32'h000D4000, 1'b0, 1'b1, 1'b0, 4'd11}, // R11 seg 5 read kept
        '{1'b0, 4'd0,  2'b00, 32'h000D4000, 1'b1, 1'b0, 1'b1, 4'd11}, // R11 seg 5 write kept
        '{1'b0, 4'd0,  2'b00, 32'h000C8000, 1'b1, 1'b1, 1'b0, 4'd11}  // R11 seg 2 untouched
    };

    task automatic check(input logic act, input logic exp, input int req, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [3:0] s, input logic [1:0] a);
        @(negedge clk);
        cfg_we = 1'b1; cfg_seg = s; cfg_attr = a;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue one request with rsp_ready high and check the response after the edge
    task automatic run_req(input logic [31:0] a, input logic w, input logic d,
                           input logic exp, input int req);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w; dflt_to_dram = d;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid, 1'b1, 9, "rsp_valid after accept");    // R9
        check(rsp_to_dram, exp, req, "target");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rsp_valid, 1'b0, 1, "rsp_valid after reset");
        check(req_ready, 1'b1, 1, "req_ready after reset");

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].do_cfg) write_cfg(VECS[i].seg, VECS[i].attr);
            run_req(VECS[i].addr, VECS[i].wr, VECS[i].dflt, VECS[i].exp, int'(VECS[i].req));
        end

        // R8: config write and request to the same segment on one edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_seg = 4'd3; cfg_attr = 2'b11;
        req_valid = 1'b1; req_addr = 32'h000CC010; req_write = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check(rsp_to_dram, 1'b0, 8, "same-cycle request uses old attr");
        run_req(32'h000CC010, 1'b0, 1'b0, 1'b1, 8);   // R8 new attr next cycle

        // R10: stall holds the response and blocks new requests
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_addr = 32'h000CC000; req_write = 1'b1; // seg 3 = 11 -> DRAM
        @(negedge clk);
        req_addr = 32'h000F0000; req_write = 1'b0;                   // seg 12 = 00 -> bus
        check(rsp_valid, 1'b1, 10, "valid during stall");
        check(rsp_to_dram, 1'b1, 10, "held decision");
        check(req_ready, 1'b0, 10, "req_ready low during stall");
        @(negedge clk);
        check(rsp_to_dram, 1'b1, 10, "held decision second cycle");
        check(req_ready, 1'b0, 10, "req_ready still low");
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid, 1'b1, 10, "waiting request taken");
        check(rsp_to_dram, 1'b0, 10, "waiting request target");
        @(negedge clk);
        check(rsp_valid, 1'b0, 9, "idle after drain");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule